// File: doc/BRIEF.md
# DMA Transaction Size Register

This block is a port-level control register that holds two burst sizes for a DMA engine. One size is for receive traffic and one is for transmit traffic. Each size is stored as a 4-bit log2 code. Software reaches the register through a simple register bus made of an address, a write enable, write data and combinational read data. The block also turns each stored code into a burst length in DWORDs, which drives the DMA engine directly.

Two rules protect the stored codes.

- **Depth clamp.** A written code that is too large for the matching FIFO is clamped to the largest code that FIFO can hold. The limits come from the FIFO-depth parameters and are computed at elaboration. The reserved codes above Ah can therefore never be stored.
- **Start lock.** While the port-start input is high, both fields are frozen and writes have no effect.

Top module: `dma_xfer_size_reg`

## Requirements
- R1: After reset both codes are 0, both length outputs read 1, and the register reads back as 0x00000000.
- R2: At address REG_ADDR (default 0x10) the register holds the receive code in bits 7:4 and the transmit code in bits 3:0. A write with wrEn high stores them, and rdData returns them in the same positions.
- R3: Each length output equals 2^code DWORDs for the stored code. The output changes at the clock edge that accepts the write.
- R4: The receive limit is min(log2(RX_FIFO_DEPTH)-2, 10). With the default depth of 128 the limit is 5. A larger written receive code stores the limit instead.
- R5: The transmit limit is min(log2(TX_FIFO_DEPTH)-1, 10). With the default depth of 32 the limit is 4. A larger written transmit code stores the limit instead.
- R6: While portStart is 1, writes leave both codes and both length outputs unchanged.
- R7: Bits 31:8 always read as zero, and written values in them have no effect.
- R8: Writes to any address other than REG_ADDR change nothing, and reads of other addresses return zero.
- R9: Clamping is applied to each field on its own within one write. A clamped field does not affect the other field's stored value.
- R10: A stored code never exceeds its field's limit, so codes Bh to Fh are never held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portStart | input | 1 | Port running; freezes both fields while high |
| addr | input | ADDR_W | Register bus address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, combinational from addr |
| rxLenDw | output | 11 | Receive burst length in DWORDs |
| txLenDw | output | 11 | Transmit burst length in DWORDs |

## Verification
The bench drives codes exactly at each limit, one above it, and the all-ones reserved value. A design that clamped at the wrong depth ratio, or that stored reserved codes, would read back the wrong code and the wrong burst length. Writes that clamp one field and not the other expose any coupling between the two clamps. Writes made while started, writes to a neighbouring address, and writes with upper bits set must leave the readback and both lengths unchanged. A leaky lock or a sloppy address decode would show up as a changed value.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int CODE_W   = 4;
  localparam int LEN_W    = 11;
  localparam int CODE_TOP = 10;

  typedef struct packed {
    logic rxLoad;
    logic txLoad;
    logic rdHit;
  } fieldStrobes_t;

  // Largest code a FIFO of 'depth' DWORDs supports: burst = depth >> shift.
  function automatic int maxCode(input int depth, input int shift);
    int c;
    c = $clog2(depth) - shift;
    if (c > CODE_TOP) c = CODE_TOP;
    if (c < 0) c = 0;
    return c;
  endfunction
endpackage

// File: rtl/dts_ctrl.sv
module dts_ctrl
  import dts_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
  parameter int RX_MAX = 5,
  parameter int TX_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portStart,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output fieldStrobes_t     strobes,
  output logic [CODE_W-1:0] rxNext,
  output logic [CODE_W-1:0] txNext
);
  localparam logic [CODE_W-1:0] RX_CAP = CODE_W'(RX_MAX);
  localparam logic [CODE_W-1:0] TX_CAP = CODE_W'(TX_MAX);

  logic              addrHit;
  logic              wrOk;
  logic [CODE_W-1:0] rxRaw;
  logic [CODE_W-1:0] txRaw;

  always_comb begin
    addrHit = (addr == REG_ADDR);
    wrOk    = addrHit && wrEn && !portStart;
    rxRaw   = wrData[2*CODE_W-1:CODE_W];
    txRaw   = wrData[CODE_W-1:0];
    rxNext  = (rxRaw > RX_CAP) ? RX_CAP : rxRaw;
    txNext  = (txRaw > TX_CAP) ? TX_CAP : txRaw;
    strobes.rxLoad = wrOk;
    strobes.txLoad = wrOk;
    strobes.rdHit  = addrHit;
  end

  p_no_load_started_r6: assert property (@(posedge clk) disable iff (!rstN)
    portStart |-> !(strobes.rxLoad || strobes.txLoad));

  p_rx_clamp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxLoad && (wrData[7:4] > RX_CAP)) |-> (rxNext == RX_CAP));

  p_tx_clamp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txLoad && (wrData[3:0] > TX_CAP)) |-> (txNext == TX_CAP));
endmodule

// File: rtl/dts_datapath.sv
module dts_datapath
  import dts_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RX_MAX = 5,
  parameter int TX_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portStart,
  input  fieldStrobes_t     strobes,
  input  logic [CODE_W-1:0] rxNext,
  input  logic [CODE_W-1:0] txNext,
  output logic [DATA_W-1:0] rdData,
  output logic [LEN_W-1:0]  rxLenDw,
  output logic [LEN_W-1:0]  txLenDw
);
  localparam int NFIELD = 2;

  logic [CODE_W-1:0] codeQ   [NFIELD];
  logic [CODE_W-1:0] codeD   [NFIELD];
  logic              loadS   [NFIELD];
  logic [LEN_W-1:0]  lenOut  [NFIELD];

  assign codeD[0] = rxNext;
  assign codeD[1] = txNext;
  assign loadS[0] = strobes.rxLoad;
  assign loadS[1] = strobes.txLoad;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)          codeQ[g] <= '0;
      else if (loadS[g])  codeQ[g] <= codeD[g];
    end
    assign lenOut[g] = LEN_W'(1) << codeQ[g];
  end

  assign rxLenDw = lenOut[0];
  assign txLenDw = lenOut[1];

  always_comb begin
    rdData = '0;
    if (strobes.rdHit) rdData[2*CODE_W-1:0] = {codeQ[0], codeQ[1]};
  end

  p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    portStart |=> ($stable(rxLenDw) && $stable(txLenDw)));

  p_rx_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    codeQ[0] <= CODE_W'(RX_MAX));

  p_tx_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    codeQ[1] <= CODE_W'(TX_MAX));

  p_len_pow2_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(rxLenDw) == 1) && ($countones(txLenDw) == 1));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:2*CODE_W] == '0);
endmodule

// File: rtl/dma_xfer_size_reg.sv
module dma_xfer_size_reg
  import dts_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
  parameter int RX_FIFO_DEPTH = 128,
  parameter int TX_FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portStart,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [10:0]       rxLenDw,
  output logic [10:0]       txLenDw
);
  localparam int RX_MAX = maxCode(RX_FIFO_DEPTH, 2);
  localparam int TX_MAX = maxCode(TX_FIFO_DEPTH, 1);

  fieldStrobes_t     strobes;
  logic [CODE_W-1:0] rxNext;
  logic [CODE_W-1:0] txNext;

  dts_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .RX_MAX(RX_MAX), .TX_MAX(TX_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portStart(portStart), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .strobes(strobes),
    .rxNext(rxNext), .txNext(txNext)
  );

  dts_datapath #(
    .DATA_W(DATA_W), .RX_MAX(RX_MAX), .TX_MAX(TX_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .portStart(portStart), .strobes(strobes),
    .rxNext(rxNext), .txNext(txNext), .rdData(rdData),
    .rxLenDw(rxLenDw), .txLenDw(txLenDw)
  );
endmodule

// File: tb/sim_dma_xfer_size_reg.sv
module sim_dma_xfer_size_reg;
  logic        clk = 0;
  logic        rstN = 0;
  logic        portStart = 0;
  logic [7:0]  addr = 8'h10;
  logic        wrEn = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [10:0] rxLenDw, txLenDw;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dma_xfer_size_reg u0 (
    .clk(clk), .rstN(rstN), .portStart(portStart), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rxLenDw(rxLenDw), .txLenDw(txLenDw)
  );

  // {start, addr, data, expRx, expTx}; defaults: rx limit 5, tx limit 4
  typedef struct packed {
    logic        st;
    logic [7:0]  ad;
    logic [31:0] dt;
    logic [3:0]  eRx;
    logic [3:0]  eTx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h10, 32'h0000_0032, 4'd3, 4'd2},  // R2 plain
    '{1'b0, 8'h10, 32'h0000_0054, 4'd5, 4'd4},  // R4 R5 at limit
    '{1'b0, 8'h10, 32'h0000_0065, 4'd5, 4'd4},  // R4 R5 one above
    '{1'b0, 8'h10, 32'h0000_00FF, 4'd5, 4'd4},  // R10 reserved
    '{1'b0, 8'h10, 32'h0000_0000, 4'd0, 4'd0},  // R3 minimum
    '{1'b0, 8'h10, 32'h0000_00A1, 4'd5, 4'd1},  // R9 rx clamps only
    '{1'b0, 8'h10, 32'h0000_002B, 4'd2, 4'd4},  // R9 tx clamps only
    '{1'b1, 8'h10, 32'h0000_0011, 4'd2, 4'd4},  // R6 locked
    '{1'b0, 8'h14, 32'h0000_0033, 4'd2, 4'd4},  // R8 other address
    '{1'b0, 8'h10, 32'hFFFF_FF13, 4'd1, 4'd3}   // R7 upper bits
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic st, input logic [7:0] ad, input logic [31:0] dt);
    @(negedge clk);
    portStart = st; addr = ad; wrData = dt; wrEn = 1;
    @(negedge clk);
    wrEn = 0; addr = 8'h10; portStart = 0;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 readback", rdData, 32'h0);
    chk("R1 rxLen", 32'(rxLenDw), 32'd1);
    chk("R1 txLen", 32'(txLenDw), 32'd1);

    for (int i = 0; i < NV; i++) begin
      doWrite(VECS[i].st, VECS[i].ad, VECS[i].dt);
      chk($sformatf("R2 vec%0d readback", i), rdData, {24'h0, VECS[i].eRx, VECS[i].eTx});
      chk($sformatf("R3 vec%0d rxLen", i), 32'(rxLenDw), 32'd1 << VECS[i].eRx);
      chk($sformatf("R3 vec%0d txLen", i), 32'(txLenDw), 32'd1 << VECS[i].eTx);
    end

    // R8: reads of another address return zero
    @(negedge clk); addr = 8'h11; #1;
    chk("R8 other read", rdData, 32'h0);
    addr = 8'h10; #1;

    // R6: lock held over several cycles with repeated writes
    @(negedge clk); portStart = 1; addr = 8'h10; wrData = 32'h0; wrEn = 1;
    repeat (3) @(negedge clk);
    wrEn = 0; #1;
    chk("R6 multi-cycle lock", rdData, 32'h13);
    portStart = 0;

    // R3: length changes at the accepting edge, not before
    @(negedge clk); wrData = 32'h44; wrEn = 1; #1;
    chk("R3 before edge", 32'(txLenDw), 32'd8);
    @(negedge clk); wrEn = 0; #1;
    chk("R3 after edge tx", 32'(txLenDw), 32'd16);
    chk("R3 after edge rx", 32'(rxLenDw), 32'd16);

    // R1: reset returns both fields to zero
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1; #1;
    chk("R1 re-reset", rdData, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule